// File: doc/BRIEF.md
# Two-Level Bus Interrupter

This block raises bus interrupt requests on behalf of two sources on one card and answers the interrupt-acknowledge cycles that follow. The disk interface requests on bus level 2 and the network controller on bus level 3. A request is posted only while the source interrupt and its enable are both high. The host loads an 8-bit vector register for each level, and that register is returned on the low data byte when the host acknowledges the matching level. A posted request is not dropped by the acknowledge. It stays up until the host touches the source's status register: the disk status register is signalled by a pulse input, and the network control register is held in this block.

The network control/status register holds the interrupt enable, loopback and controller-reset controls. It also has a write-only attention bit that sends a one-clock pulse to the network controller. The acknowledge daisy chain is handled by a small state machine with three states. `ST_IDLE` waits for a cycle. `ST_ANSWER` drives the acknowledge and the vector. `ST_PASS` forwards the grant downstream. Two transitions leave `ST_IDLE`: to `ST_ANSWER` when the presented level code matches a pending level of this card, and to `ST_PASS` otherwise. Both `ST_ANSWER` and `ST_PASS` return to `ST_IDLE` once the acknowledge cycle ends.

Top module: `dual_level_interrupter`

## Requirements
- R1: `bus_irq2` goes high one clock after `disk_irq` and `disk_ie` first become both high. It never rises while either is low.
- R2: `bus_irq3` goes high one clock after `net_irq` and the stored enable (control register bit 12) first become both high. It never rises while either is low.
- R3: A posted request stays high through acknowledge cycles. It is released only by an access to its source register: a `disk_stat_acc` pulse for level 2, or any read or write of host address 2 for level 3. The release takes effect on the next clock. A source still held high does not re-post until it falls and rises again. A new rise in the same clock as the access leaves the request posted.
- R4: Host address 0 holds the level-2 vector and address 1 holds the level-3 vector. Each is written from `host_wdata[7:0]` and read back in `host_rdata[7:0]` with bits 15..8 zero. Address 3 reads 0.
- R5: With `iack_cyc` and `iack_in` high and a level code of 2 (or 3) whose request is posted, `iack_ack` goes high one clock later. While it is high, `iack_vec` carries that level's vector, held until `iack_cyc` drops. One clock after `iack_cyc` drops, `iack_ack` and `iack_vec` are 0.
- R6: With `iack_cyc` and `iack_in` high and any other level code, or level 2/3 with no posted request, `iack_out` goes high one clock later, with `iack_ack` low and `iack_vec` 0. It falls one clock after `iack_cyc` drops.
- R7: A read of address 2 returns the live `net_irq` in bit 8, the interrupt enable in bit 12, loopback in bit 14 and controller reset in bit 15. Bits 0–7, 9–11 and 13 read 0.
- R8: A write to address 2 stores bits 12, 14 and 15. Bit 14 drives `net_loop` and bit 15 drives `net_reset` until the next write. Other written bits have no effect.
- R9: A write to address 2 with bit 13 set gives `net_attn` high for exactly the one clock after the write. A write with bit 13 clear gives no pulse.
- R10: After reset all outputs are 0, and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 2 | Register select: 0 level-2 vector, 1 level-3 vector, 2 network control, 3 unused |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for the selected register |
| disk_irq | input | 1 | Disk interface interrupt |
| disk_ie | input | 1 | Disk interface interrupt enable |
| disk_stat_acc | input | 1 | Pulse: host accessed the disk status register |
| net_irq | input | 1 | Network controller interrupt |
| net_attn | output | 1 | One-clock attention pulse to the network controller |
| net_loop | output | 1 | Network loopback control |
| net_reset | output | 1 | Network controller reset |
| bus_irq2 | output | 1 | Level-2 bus request, active high |
| bus_irq3 | output | 1 | Level-3 bus request, active high |
| iack_cyc | input | 1 | Acknowledge cycle in progress |
| iack_level | input | 3 | Level code being acknowledged |
| iack_in | input | 1 | Daisy-chain grant in |
| iack_out | output | 1 | Daisy-chain grant out |
| iack_ack | output | 1 | This card answers the acknowledge |
| iack_vec | output | 8 | Vector driven during an answer |

## Verification
The hardest situation to reach is an acknowledge that arrives while only some combination of the two levels is posted. Each level's posted state depends on an edge in the past and on whether an access has released it since. The bench therefore builds every posted combination deliberately: it lowers both sources, releases both levels through register accesses, and raises only the chosen sources. It then sweeps all eight level codes against each combination and computes answer, pass and vector arithmetically. The case where a source rises in the same clock as the release access is driven directly by putting both on one edge.

// File: rtl/dli_pkg.sv
package dli_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_ANSWER, ST_PASS} ack_state_t;

    localparam int CSR_W       = 16;
    localparam int BIT_NIRQ    = 8;
    localparam int BIT_IE      = 12;
    localparam int BIT_ATTN    = 13;
    localparam int BIT_LOOP    = 14;
    localparam int BIT_RESET   = 15;

    localparam logic [1:0] ADDR_VEC_BASE = 2'd0;
    localparam logic [1:0] ADDR_NCSR     = 2'd2;
endpackage

// File: rtl/dli_pend_cell.sv
module dli_pend_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic en_i,
    input  logic release_i,
    output logic pending_o
);
    logic gated;
    logic gated_q;

    assign gated = src_i & en_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gated_q   <= 1'b0;
            pending_o <= 1'b0;
        end else begin
            gated_q <= gated;
            if (gated && !gated_q)
                pending_o <= 1'b1;
            else if (release_i)
                pending_o <= 1'b0;
        end
    end
endmodule

// File: rtl/dli_net_csr.sv
module dli_net_csr
    import dli_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CSR_W-1:0] wdata_i,
    input  logic             net_irq_i,
    output logic [CSR_W-1:0] rdata_o,
    output logic             ie_o,
    output logic             loop_o,
    output logic             reset_o,
    output logic             attn_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_o    <= 1'b0;
            loop_o  <= 1'b0;
            reset_o <= 1'b0;
            attn_o  <= 1'b0;
        end else if (wr_i) begin
            ie_o    <= wdata_i[BIT_IE];
            loop_o  <= wdata_i[BIT_LOOP];
            reset_o <= wdata_i[BIT_RESET];
            attn_o  <= wdata_i[BIT_ATTN];
        end else begin
            attn_o  <= 1'b0;
        end
    end

    always_comb begin
        rdata_o            = '0;
        rdata_o[BIT_NIRQ]  = net_irq_i;
        rdata_o[BIT_IE]    = ie_o;
        rdata_o[BIT_LOOP]  = loop_o;
        rdata_o[BIT_RESET] = reset_o;
    end
endmodule

// File: rtl/dli_iack_fsm.sv
module dli_iack_fsm
    import dli_pkg::*;
#(
    parameter int LVL_W    = 3,
    parameter int VEC_W    = 8,
    parameter int LEVEL_LO = 2,
    parameter int LEVEL_HI = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_i,
    input  logic             chain_in_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic             pend_lo_i,
    input  logic             pend_hi_i,
    input  logic [VEC_W-1:0] vec_lo_i,
    input  logic [VEC_W-1:0] vec_hi_i,
    output logic             ack_o,
    output logic             chain_out_o,
    output logic [VEC_W-1:0] vec_o
);
    ack_state_t state, state_nx;
    logic [VEC_W-1:0] vec_q;
    logic hit_lo, hit_hi, start;

    assign hit_lo = (level_i == LVL_W'(LEVEL_LO)) && pend_lo_i;
    assign hit_hi = (level_i == LVL_W'(LEVEL_HI)) && pend_hi_i;
    assign start  = cyc_i && chain_in_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nx = (hit_lo || hit_hi) ? ST_ANSWER : ST_PASS;
            end
            ST_ANSWER, ST_PASS: begin
                if (!cyc_i) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            vec_q <= '0;
        else if (state == ST_IDLE && start)
            vec_q <= hit_hi ? vec_hi_i : vec_lo_i;
    end

    always_comb begin
        ack_o       = 1'b0;
        chain_out_o = 1'b0;
        vec_o       = '0;
        unique case (state)
            ST_IDLE:   ;
            ST_ANSWER: begin
                ack_o = 1'b1;
                vec_o = vec_q;
            end
            ST_PASS:   chain_out_o = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/dual_level_interrupter.sv
module dual_level_interrupter
    import dli_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int LVL_W    = 3,
    parameter int LEVEL_LO = 2,
    parameter int LEVEL_HI = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       host_addr,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [CSR_W-1:0] host_wdata,
    output logic [CSR_W-1:0] host_rdata,
    input  logic             disk_irq,
    input  logic             disk_ie,
    input  logic             disk_stat_acc,
    input  logic             net_irq,
    output logic             net_attn,
    output logic             net_loop,
    output logic             net_reset,
    output logic             bus_irq2,
    output logic             bus_irq3,
    input  logic             iack_cyc,
    input  logic [LVL_W-1:0] iack_level,
    input  logic             iack_in,
    output logic             iack_out,
    output logic             iack_ack,
    output logic [VEC_W-1:0] iack_vec
);
    localparam int NUM_LVL = 2;
    localparam int PAD_W   = CSR_W - VEC_W;

    logic [NUM_LVL-1:0] src, en, rel, pend;
    logic [VEC_W-1:0]   vec_q [NUM_LVL];
    logic [CSR_W-1:0]   csr_rdata;
    logic               net_ie;
    logic               csr_sel;

    assign csr_sel = (host_addr == ADDR_NCSR);

    assign src = {net_irq, disk_irq};
    assign en  = {net_ie,  disk_ie};
    assign rel = {csr_sel && (host_wr || host_rd), disk_stat_acc};

    generate
        for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
            dli_pend_cell u_pend (
                .clk       (clk),
                .rst_n     (rst_n),
                .src_i     (src[g]),
                .en_i      (en[g]),
                .release_i (rel[g]),
                .pending_o (pend[g])
            );

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    vec_q[g] <= '0;
                else if (host_wr && host_addr == ADDR_VEC_BASE + 2'(g))
                    vec_q[g] <= host_wdata[VEC_W-1:0];
            end
        end
    endgenerate

    assign bus_irq2 = pend[0];
    assign bus_irq3 = pend[1];

    dli_net_csr u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (host_wr && csr_sel),
        .wdata_i   (host_wdata),
        .net_irq_i (net_irq),
        .rdata_o   (csr_rdata),
        .ie_o      (net_ie),
        .loop_o    (net_loop),
        .reset_o   (net_reset),
        .attn_o    (net_attn)
    );

    dli_iack_fsm #(
        .LVL_W    (LVL_W),
        .VEC_W    (VEC_W),
        .LEVEL_LO (LEVEL_LO),
        .LEVEL_HI (LEVEL_HI)
    ) u_iack (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_i       (iack_cyc),
        .chain_in_i  (iack_in),
        .level_i     (iack_level),
        .pend_lo_i   (pend[0]),
        .pend_hi_i   (pend[1]),
        .vec_lo_i    (vec_q[0]),
        .vec_hi_i    (vec_q[1]),
        .ack_o       (iack_ack),
        .chain_out_o (iack_out),
        .vec_o       (iack_vec)
    );

    always_comb begin
        host_rdata = '0;
        if (host_addr == ADDR_VEC_BASE)
            host_rdata = {{PAD_W{1'b0}}, vec_q[0]};
        else if (host_addr == ADDR_VEC_BASE + 2'd1)
            host_rdata = {{PAD_W{1'b0}}, vec_q[1]};
        else if (csr_sel)
            host_rdata = csr_rdata;
    end
endmodule

// File: rtl/dli_chk.sv
module dli_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  host_addr,
    input logic        host_wr,
    input logic [15:0] host_wdata,
    input logic        disk_irq,
    input logic        disk_ie,
    input logic        disk_stat_acc,
    input logic        net_irq,
    input logic        net_ie,
    input logic        net_attn,
    input logic        bus_irq2,
    input logic        bus_irq3,
    input logic        iack_cyc,
    input logic        iack_out,
    input logic        iack_ack
);
    AST_IRQ2_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_irq2) |-> $past(disk_irq && disk_ie)); // R1

    AST_IRQ3_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_irq3) |-> $past(net_irq && net_ie)); // R2

    AST_IRQ2_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (disk_stat_acc && !(disk_irq && disk_ie)) |=> !bus_irq2); // R3

    AST_ACK_HAS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iack_ack) |-> $past(bus_irq2 || bus_irq3)); // R5

    AST_ACK_PASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(iack_ack && iack_out)); // R6

    AST_PASS_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        iack_out |-> $past(iack_cyc)); // R6

    AST_ATTN_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        net_attn |-> $past(host_wr && host_addr == 2'd2 && host_wdata[13])); // R9
endmodule

bind dual_level_interrupter dli_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_addr     (host_addr),
    .host_wr       (host_wr),
    .host_wdata    (host_wdata),
    .disk_irq      (disk_irq),
    .disk_ie       (disk_ie),
    .disk_stat_acc (disk_stat_acc),
    .net_irq       (net_irq),
    .net_ie        (net_ie),
    .net_attn      (net_attn),
    .bus_irq2      (bus_irq2),
    .bus_irq3      (bus_irq3),
    .iack_cyc      (iack_cyc),
    .iack_out      (iack_out),
    .iack_ack      (iack_ack)
);

// File: tb/sim_dual_level_interrupter.sv
`timescale 1ns/1ps
module sim_dual_level_interrupter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        disk_irq = 1'b0, disk_ie = 1'b0, disk_stat_acc = 1'b0;
    logic        net_irq = 1'b0;
    logic        net_attn, net_loop, net_reset, bus_irq2, bus_irq3;
    logic        iack_cyc = 1'b0, iack_in = 1'b0;
    logic [2:0]  iack_level = '0;
    logic        iack_out, iack_ack;
    logic [7:0]  iack_vec;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dual_level_interrupter u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic disk_access();
        @(negedge clk);
        disk_stat_acc = 1'b1;
        @(negedge clk);
        disk_stat_acc = 1'b0;
    endtask

    // Lower both sources, release both levels, then raise the chosen ones.
    task automatic set_pend(input bit p2, input bit p3);
        @(negedge clk);
        disk_irq = 1'b0; net_irq = 1'b0; disk_ie = 1'b1;
        host_write(2'd2, 16'h1000);
        disk_access();
        disk_irq = p2; net_irq = p3;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            summary();
        end
    end

    initial begin
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 irq2", 32'(bus_irq2), 0);
        check("R10 irq3", 32'(bus_irq3), 0);
        check("R10 ack/out", {30'b0, iack_ack, iack_out}, 0);
        check("R10 net outs", {29'b0, net_attn, net_loop, net_reset}, 0);
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) begin
            host_read(2'(a), rd);
            check("R10 reg reset", 32'(rd), 0);
        end

        // R4 vector registers
        for (int i = 0; i < 16; i++) begin
            host_write(2'd0, 16'((i * 17) | 16'hAB00));
            host_write(2'd1, 16'(((255 - i * 13) & 255) | 16'h5400));
            host_read(2'd0, rd);
            check("R4 vec2", 32'(rd), 32'(i * 17));
            host_read(2'd1, rd);
            check("R4 vec3", 32'(rd), 32'((255 - i * 13) & 255));
            host_read(2'd3, rd);
            check("R4 addr3", 32'(rd), 0);
        end

        // R7 R8 R9 control register sweep
        for (int p = 0; p < 16; p++) begin
            logic [15:0] w;
            logic [15:0] e;
            net_irq = p[0] ^ p[3];
            w = 16'((p << 12) | 16'h0A5F);
            @(negedge clk);
            host_addr = 2'd2; host_wdata = w; host_wr = 1'b1;
            @(negedge clk);
            host_wr = 1'b0;
            check("R9 attn pulse", 32'(net_attn), 32'(p[1]));
            check("R8 loop", 32'(net_loop), 32'(p[2]));
            check("R8 reset", 32'(net_reset), 32'(p[3]));
            @(negedge clk);
            check("R9 attn one clock", 32'(net_attn), 0);
            host_read(2'd2, rd);
            e = 16'((p[0] << 12) | (p[2] << 14) | (p[3] << 15) | ((p[0] ^ p[3]) << 8));
            check("R7 csr read", 32'(rd), 32'(e));
        end
        host_write(2'd2, 16'h0000);
        net_irq = 1'b0;

        // R1 R2 gating sweep
        for (int c = 0; c < 4; c++) begin
            set_pend(0, 0);
            host_write(2'd2, c[1] ? 16'h1000 : 16'h0000);
            @(negedge clk);
            disk_ie = c[1]; disk_irq = c[0]; net_irq = c[0];
            @(negedge clk);
            check("R1 irq2 gating", 32'(bus_irq2), 32'(c[0] & c[1]));
            check("R2 irq3 gating", 32'(bus_irq3), 32'(c[0] & c[1]));
        end

        // R3 release behaviour
        set_pend(1, 1);
        check("R3 both posted", {30'b0, bus_irq3, bus_irq2}, 3);
        @(negedge clk);
        iack_cyc = 1'b1; iack_in = 1'b1; iack_level = 3'd2;
        @(negedge clk);
        iack_cyc = 1'b0; iack_in = 1'b0;
        @(negedge clk);
        check("R3 held after ack", {30'b0, bus_irq3, bus_irq2}, 3);
        disk_access();
        check("R3 disk release", {30'b0, bus_irq3, bus_irq2}, 2);
        host_read(2'd2, rd);
        check("R3 csr read release", 32'(bus_irq3), 0);
        repeat (3) @(negedge clk);
        check("R3 no repost while held", {30'b0, bus_irq3, bus_irq2}, 0);
        disk_irq = 1'b0;
        @(negedge clk);
        disk_irq = 1'b1; disk_stat_acc = 1'b1;
        @(negedge clk);
        disk_stat_acc = 1'b0;
        check("R3 rise beats access", 32'(bus_irq2), 1);
        net_irq = 1'b0;
        @(negedge clk);
        net_irq = 1'b1;
        @(negedge clk);
        check("R3 repost after edge", 32'(bus_irq3), 1);
        host_write(2'd2, 16'h1000);
        check("R3 csr write release", 32'(bus_irq3), 0);

        // R5 R6 acknowledge sweep
        for (int p = 0; p < 4; p++) begin
            for (int L = 0; L < 8; L++) begin
                logic [7:0] v2, v3;
                bit ans;
                logic [7:0] ev;
                v2 = 8'(16 * L + 4 * p + 1);
                v3 = 8'(255 - 16 * L - p);
                host_write(2'd0, {8'h00, v2});
                host_write(2'd1, {8'h00, v3});
                set_pend(p[0], p[1]);
                ans = (L == 2 && p[0]) || (L == 3 && p[1]);
                ev  = !ans ? 8'h00 : (L == 2 ? v2 : v3);
                @(negedge clk);
                iack_cyc = 1'b1; iack_in = 1'b1; iack_level = 3'(L);
                @(negedge clk);
                check("R5 ack", 32'(iack_ack), 32'(ans));
                check("R5 vec", 32'(iack_vec), 32'(ev));
                check("R6 pass", 32'(iack_out), 32'(!ans));
                @(negedge clk);
                check("R5 vec held", 32'(iack_vec), 32'(ev));
                iack_cyc = 1'b0; iack_in = 1'b0;
                @(negedge clk);
                check("R5 R6 end of cycle", {22'b0, iack_vec, iack_ack, iack_out}, 0);
                check("R3 posted after ack", {30'b0, bus_irq3, bus_irq2}, 32'(p));
            end
        end

        finished = 1'b1;
        summary();
    end
endmodule